// File: doc/BRIEF.md
# FIFO Threshold DMA Event Generator

This block carries the word FIFOs of an audio serial port and the logic that asks a DMA engine for service. It has one receive FIFO and one transmit FIFO, each 64 words of 32 bits. On the receive side the serializer pushes words and the DMA engine pops them. On the transmit side the DMA engine pushes words and the serializer pops them. Each direction has a programmable threshold. Every time the serializer side has moved that many words, one service request is owed to the DMA engine. Every time the DMA side has moved that many words, one request is paid off.

The DMA request for each direction is a level. It stays high while at least one request is owed. Owed requests are held in a saturating counter, not in a set/reset flop. A request raised in the same cycle as a service completion, or one or two cycles around it, therefore always survives, because the two effects add. A lost request would starve the DMA engine and make the receive FIFO overflow or the transmit FIFO underflow. Both of those error conditions are caught in sticky flags that software clears through the configuration port.

Top module: `fifo_dma_event_gen`

## Requirements
- R1: Each direction has a first-in first-out store of 64 words of 32 bits. The oldest word is shown on that direction's read-data output while the store is not empty. A push into a full store is not stored. A pop from an empty store changes nothing. A push and a pop in the same cycle are both taken when the store is neither full nor empty.
- R2: The configuration port sets the thresholds. A write with address 0 sets the receive threshold and address 1 sets the transmit threshold, with the value taken from the write data. A value of 0 acts as 1, and a value above 32 acts as 32. A threshold write restarts both word counts of that direction at zero. After reset both thresholds are 1.
- R3: When the serializer side accepts the word that completes a threshold count, one request becomes owed. This is a receive push or a transmit pop. The direction's event output is high from the clock edge that accepts that word.
- R4: When the DMA side accepts the word that completes a threshold count, one owed request is paid off. This is a receive pop or a transmit push. The event output falls at that edge if no request remains owed.
- R5: When a request is raised and one is paid off in the same cycle, the owed count does not change and the event output keeps its level.
- R6: Owed requests accumulate. The event stays high until as many threshold counts have completed on the DMA side as on the serializer side.
- R7: A threshold count completed on the DMA side while nothing is owed has no effect. The next request raised afterwards drives the event high.
- R8: A receive push attempted while the receive store is full sets the sticky receive-overflow flag. The word is discarded and does not count toward the threshold.
- R9: A transmit pop attempted while the transmit store is empty sets the sticky transmit-underflow flag and does not count toward the threshold.
- R10: A configuration write with address 2 clears the receive-overflow flag when data bit 0 is 1, and clears the transmit-underflow flag when data bit 1 is 1. An error arriving in the same cycle as its clear leaves the flag set.
- R11: After reset both stores are empty, both event outputs are low and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration address: 0 receive threshold, 1 transmit threshold, 2 error clear |
| cfgWdata | input | THR_W (6) | Configuration write data |
| rxPinPush | input | 1 | Serializer pushes a received word |
| rxPinData | input | WIDTH (32) | Received word from the serializer |
| rxDmaPop | input | 1 | DMA engine pops a received word |
| rxDmaData | output | WIDTH (32) | Oldest received word |
| txDmaPush | input | 1 | DMA engine pushes a word to transmit |
| txDmaData | input | WIDTH (32) | Word from the DMA engine |
| txPinPop | input | 1 | Serializer pops a word to transmit |
| txPinData | output | WIDTH (32) | Oldest word to transmit |
| rxEvent | output | 1 | Receive DMA request level |
| txEvent | output | 1 | Transmit DMA request level |
| rxOverflow | output | 1 | Sticky receive-overflow flag |
| txUnderflow | output | 1 | Sticky transmit-underflow flag |

## Verification
Events and error flags are registered. Each one reflects a stimulus in the cycle after the clock edge that samples it. FIFO read data is combinational from the head pointer, so it is valid in the same cycle as the pop strobe, before the edge that advances the pointer. The bench drives inputs two time units after a rising edge. It checks event and flag levels right after the edge that consumed the stimulus. Its monitor compares the head word against the scoreboard queue at the falling edge of each cycle in which a pop is requested on a non-empty store.

// File: rtl/fde_pkg.sv
package fde_pkg;
  localparam int NUM_DIR = 2;
  localparam int DIR_RX  = 0;
  localparam int DIR_TX  = 1;

  localparam logic [1:0] CFG_RX_THR  = 2'd0;
  localparam logic [1:0] CFG_TX_THR  = 2'd1;
  localparam logic [1:0] CFG_ERR_CLR = 2'd2;

  // strobes from control to datapath, bit index = direction
  typedef struct packed {
    logic [NUM_DIR-1:0] push;
    logic [NUM_DIR-1:0] pop;
  } fifoCmd_t;

  // occupancy status from datapath to control
  typedef struct packed {
    logic [NUM_DIR-1:0] full;
    logic [NUM_DIR-1:0] empty;
  } fifoStat_t;
endpackage

// File: rtl/fde_datapath.sv
module fde_datapath
  import fde_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  fifoCmd_t                        cmd,
  input  logic [NUM_DIR-1:0][WIDTH-1:0]   wrData,
  output logic [NUM_DIR-1:0][WIDTH-1:0]   rdData,
  output fifoStat_t                       stat
);
  // DEPTH is expected to be a power of two
  localparam int AW = $clog2(DEPTH);

  logic [NUM_DIR-1:0] fullV;
  logic [NUM_DIR-1:0] emptyV;

  generate
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      logic [WIDTH-1:0] mem [DEPTH];
      logic [AW:0]      wrPtr;
      logic [AW:0]      rdPtr;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          wrPtr <= '0;
          rdPtr <= '0;
        end else begin
          if (cmd.push[d]) wrPtr <= wrPtr + (AW+1)'(1);
          if (cmd.pop[d])  rdPtr <= rdPtr + (AW+1)'(1);
        end
      end

      always_ff @(posedge clk) begin
        if (cmd.push[d]) mem[wrPtr[AW-1:0]] <= wrData[d];
      end

      assign rdData[d] = mem[rdPtr[AW-1:0]];
      assign fullV[d]  = (wrPtr[AW] != rdPtr[AW]) &&
                         (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
      assign emptyV[d] = (wrPtr == rdPtr);
    end
  endgenerate

  assign stat = '{full: fullV, empty: emptyV};
endmodule

// File: rtl/fde_control.sv
module fde_control
  import fde_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int MAX_THR = 32,
  parameter int THR_W   = $clog2(MAX_THR) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [1:0]         cfgAddr,
  input  logic [THR_W-1:0]   cfgWdata,
  input  logic               rxPinPush,
  input  logic               rxDmaPop,
  input  logic               txDmaPush,
  input  logic               txPinPop,
  input  fifoStat_t          stat,
  output fifoCmd_t           cmd,
  output logic [NUM_DIR-1:0] setHit,
  output logic [NUM_DIR-1:0] clrHit,
  output logic [NUM_DIR-1:0] dmaEvent,
  output logic               rxOverflow,
  output logic               txUnderflow
);
  localparam int                PEND_W   = $clog2(DEPTH + 1);
  localparam logic [PEND_W-1:0] PEND_MAX = PEND_W'(DEPTH);

  logic [NUM_DIR-1:0] pinAcc;
  logic [NUM_DIR-1:0] dmaAcc;
  logic [NUM_DIR-1:0] thrWr;
  logic               errClr;

  // acceptance: full blocks a push, empty blocks a pop
  assign pinAcc[DIR_RX] = rxPinPush & ~stat.full[DIR_RX];
  assign dmaAcc[DIR_RX] = rxDmaPop  & ~stat.empty[DIR_RX];
  assign dmaAcc[DIR_TX] = txDmaPush & ~stat.full[DIR_TX];
  assign pinAcc[DIR_TX] = txPinPop  & ~stat.empty[DIR_TX];

  assign cmd = '{push: {dmaAcc[DIR_TX], pinAcc[DIR_RX]},
                 pop:  {pinAcc[DIR_TX], dmaAcc[DIR_RX]}};

  assign thrWr[DIR_RX] = cfgWe && (cfgAddr == CFG_RX_THR);
  assign thrWr[DIR_TX] = cfgWe && (cfgAddr == CFG_TX_THR);
  assign errClr        = cfgWe && (cfgAddr == CFG_ERR_CLR);

  function automatic logic [THR_W-1:0] clampThr(input logic [THR_W-1:0] v);
    if (v == '0)                    return THR_W'(1);
    else if (v > THR_W'(MAX_THR))   return THR_W'(MAX_THR);
    else                            return v;
  endfunction

  generate
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_evt
      logic [THR_W-1:0]  thr;
      logic [THR_W-1:0]  pinCnt;
      logic [THR_W-1:0]  dmaCnt;
      logic [PEND_W-1:0] pend;

      assign setHit[d] = pinAcc[d] && (pinCnt == thr - THR_W'(1));
      assign clrHit[d] = dmaAcc[d] && (dmaCnt == thr - THR_W'(1));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          thr    <= THR_W'(1);
          pinCnt <= '0;
          dmaCnt <= '0;
        end else if (thrWr[d]) begin
          thr    <= clampThr(cfgWdata);
          pinCnt <= '0;
          dmaCnt <= '0;
        end else begin
          if (pinAcc[d]) pinCnt <= setHit[d] ? '0 : pinCnt + THR_W'(1);
          if (dmaAcc[d]) dmaCnt <= clrHit[d] ? '0 : dmaCnt + THR_W'(1);
        end
      end

      // owed-request counter: set and clear together give net zero
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pend <= '0;
        end else begin
          unique case ({setHit[d], clrHit[d]})
            2'b10:   if (pend != PEND_MAX) pend <= pend + PEND_W'(1);
            2'b01:   if (pend != '0)       pend <= pend - PEND_W'(1);
            default: pend <= pend;
          endcase
        end
      end

      assign dmaEvent[d] = (pend != '0);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxOverflow  <= 1'b0;
      txUnderflow <= 1'b0;
    end else begin
      if (rxPinPush && stat.full[DIR_RX])      rxOverflow <= 1'b1;
      else if (errClr && cfgWdata[0])          rxOverflow <= 1'b0;
      if (txPinPop && stat.empty[DIR_TX])      txUnderflow <= 1'b1;
      else if (errClr && cfgWdata[1])          txUnderflow <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_dma_event_gen.sv
module fifo_dma_event_gen
  import fde_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int DEPTH   = 64,
  parameter int MAX_THR = 32,
  parameter int THR_W   = $clog2(MAX_THR) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgAddr,
  input  logic [THR_W-1:0] cfgWdata,
  input  logic             rxPinPush,
  input  logic [WIDTH-1:0] rxPinData,
  input  logic             rxDmaPop,
  output logic [WIDTH-1:0] rxDmaData,
  input  logic             txDmaPush,
  input  logic [WIDTH-1:0] txDmaData,
  input  logic             txPinPop,
  output logic [WIDTH-1:0] txPinData,
  output logic             rxEvent,
  output logic             txEvent,
  output logic             rxOverflow,
  output logic             txUnderflow
);
  fifoCmd_t                      fifoCmd;
  fifoStat_t                     fifoStat;
  logic [NUM_DIR-1:0][WIDTH-1:0] wrData;
  logic [NUM_DIR-1:0][WIDTH-1:0] rdData;
  logic [NUM_DIR-1:0]            setHit;
  logic [NUM_DIR-1:0]            clrHit;
  logic [NUM_DIR-1:0]            dmaEvent;

  assign wrData[DIR_RX] = rxPinData;
  assign wrData[DIR_TX] = txDmaData;
  assign rxDmaData      = rdData[DIR_RX];
  assign txPinData      = rdData[DIR_TX];
  assign rxEvent        = dmaEvent[DIR_RX];
  assign txEvent        = dmaEvent[DIR_TX];

  fde_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (fifoCmd),
    .wrData (wrData),
    .rdData (rdData),
    .stat   (fifoStat)
  );

  fde_control #(.DEPTH(DEPTH), .MAX_THR(MAX_THR), .THR_W(THR_W)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWe       (cfgWe),
    .cfgAddr     (cfgAddr),
    .cfgWdata    (cfgWdata),
    .rxPinPush   (rxPinPush),
    .rxDmaPop    (rxDmaPop),
    .txDmaPush   (txDmaPush),
    .txPinPop    (txPinPop),
    .stat        (fifoStat),
    .cmd         (fifoCmd),
    .setHit      (setHit),
    .clrHit      (clrHit),
    .dmaEvent    (dmaEvent),
    .rxOverflow  (rxOverflow),
    .txUnderflow (txUnderflow)
  );
endmodule

// File: rtl/fde_checker.sv
module fde_checker
  import fde_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_DIR-1:0] setHit,
  input logic [NUM_DIR-1:0] clrHit,
  input logic [NUM_DIR-1:0] dmaEvent,
  input fifoStat_t          stat,
  input logic               cfgWe,
  input logic [1:0]         cfgAddr,
  input logic [1:0]         cfgBits,
  input logic               rxPinPush,
  input logic               txPinPop,
  input logic               rxOverflow,
  input logic               txUnderflow
);
  logic errClrRx;
  logic errClrTx;
  assign errClrRx = cfgWe && (cfgAddr == CFG_ERR_CLR) && cfgBits[0];
  assign errClrTx = cfgWe && (cfgAddr == CFG_ERR_CLR) && cfgBits[1];

  generate
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      a_r1_full_excl_empty: assert property (@(posedge clk) disable iff (!rstN)
        !(stat.full[d] && stat.empty[d]));
      a_r3_set_raises: assert property (@(posedge clk) disable iff (!rstN)
        setHit[d] && !clrHit[d] |=> dmaEvent[d]);
      a_r5_pair_holds: assert property (@(posedge clk) disable iff (!rstN)
        setHit[d] && clrHit[d] |=> dmaEvent[d] == $past(dmaEvent[d]));
      a_r6_rise_needs_set: assert property (@(posedge clk) disable iff (!rstN)
        $rose(dmaEvent[d]) |-> $past(setHit[d]));
      a_r4_fall_needs_clear: assert property (@(posedge clk) disable iff (!rstN)
        $fell(dmaEvent[d]) |-> $past(clrHit[d]) && !$past(setHit[d]));
      a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
        !setHit[d] && !clrHit[d] |=> $stable(dmaEvent[d]));
    end
  endgenerate

  a_r8_overflow_flags: assert property (@(posedge clk) disable iff (!rstN)
    rxPinPush && stat.full[DIR_RX] |=> rxOverflow);
  a_r9_underflow_flags: assert property (@(posedge clk) disable iff (!rstN)
    txPinPop && stat.empty[DIR_TX] |=> txUnderflow);
  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rxOverflow && !errClrRx |=> rxOverflow);
  a_r10_underflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    txUnderflow && !errClrTx |=> txUnderflow);
endmodule

bind fifo_dma_event_gen fde_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .setHit      (setHit),
  .clrHit      (clrHit),
  .dmaEvent    (dmaEvent),
  .stat        (fifoStat),
  .cfgWe       (cfgWe),
  .cfgAddr     (cfgAddr),
  .cfgBits     (cfgWdata[1:0]),
  .rxPinPush   (rxPinPush),
  .txPinPop    (txPinPop),
  .rxOverflow  (rxOverflow),
  .txUnderflow (txUnderflow)
);

// File: tb/tb_fifo_dma_event_gen.sv
module tb_fifo_dma_event_gen;
  localparam int WIDTH = 32;
  localparam int DEPTH = 64;
  localparam int THR_W = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWe = 1'b0;
  logic [1:0]       cfgAddr = '0;
  logic [THR_W-1:0] cfgWdata = '0;
  logic             rxPinPush = 1'b0;
  logic [WIDTH-1:0] rxPinData = '0;
  logic             rxDmaPop = 1'b0;
  logic [WIDTH-1:0] rxDmaData;
  logic             txDmaPush = 1'b0;
  logic [WIDTH-1:0] txDmaData = '0;
  logic             txPinPop = 1'b0;
  logic [WIDTH-1:0] txPinData;
  logic             rxEvent, txEvent, rxOverflow, txUnderflow;

  int nChecks = 0;
  int nBad = 0;
  logic [WIDTH-1:0] rxQ[$];
  logic [WIDTH-1:0] txQ[$];
  logic [WIDTH-1:0] rxSeq = 32'hA500_0000;
  logic [WIDTH-1:0] txSeq = 32'h5C00_0000;

  always #10 clk = ~clk;   // 50 MHz

  fifo_dma_event_gen dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .rxPinPush(rxPinPush), .rxPinData(rxPinData), .rxDmaPop(rxDmaPop), .rxDmaData(rxDmaData),
    .txDmaPush(txDmaPush), .txDmaData(txDmaData), .txPinPop(txPinPop), .txPinData(txPinData),
    .rxEvent(rxEvent), .txEvent(txEvent), .rxOverflow(rxOverflow), .txUnderflow(txUnderflow)
  );

  task automatic chk(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // driver: applies strobes for n cycles, pushes expected words into the scoreboard
  task automatic drive(input logic rp, input logic rd, input logic td, input logic tp, input int n);
    for (int i = 0; i < n; i++) begin
      rxPinPush = rp; rxDmaPop = rd; txDmaPush = td; txPinPop = tp;
      rxPinData = rxSeq; txDmaData = txSeq;
      if (rp) begin
        if (rxQ.size() < DEPTH) rxQ.push_back(rxSeq);
        rxSeq++;
      end
      if (td) begin
        if (txQ.size() < DEPTH) txQ.push_back(txSeq);
        txSeq++;
      end
      step();
    end
    rxPinPush = 1'b0; rxDmaPop = 1'b0; txDmaPush = 1'b0; txPinPop = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] a, input logic [THR_W-1:0] v);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = v;
    step();
    cfgWe = 1'b0;
  endtask

  // monitor: compares the head word against the scoreboard on every pop of a non-empty store
  always @(negedge clk) begin
    if (rstN && rxDmaPop && rxQ.size() > 0) chk("R1 rx data order", rxDmaData, rxQ.pop_front());
    if (rstN && txPinPop && txQ.size() > 0) chk("R1 tx data order", txPinData, txQ.pop_front());
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
  endtask

  initial begin
    #3_000_000;
    nChecks++;
    nBad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    step();
    // R11 reset state
    chk("R11 rxEvent", rxEvent, 0);
    chk("R11 txEvent", txEvent, 0);
    chk("R11 rxOverflow", rxOverflow, 0);
    chk("R11 txUnderflow", txUnderflow, 0);

    // R2: threshold 0 acts as 1
    cfg(2'd0, 6'd0);
    drive(1, 0, 0, 0, 1);
    chk("R2 R3 thr0 single push raises", rxEvent, 1);
    drive(0, 1, 0, 0, 1);
    chk("R4 single pop clears", rxEvent, 0);

    // R3 / R6 with threshold 4
    cfg(2'd0, 6'd4);
    drive(1, 0, 0, 0, 3);
    chk("R3 below threshold", rxEvent, 0);
    drive(1, 0, 0, 0, 1);
    chk("R3 at threshold", rxEvent, 1);
    drive(1, 0, 0, 0, 4);
    chk("R6 second owed", rxEvent, 1);
    drive(0, 1, 0, 0, 4);
    chk("R6 one of two paid", rxEvent, 1);
    drive(0, 1, 0, 0, 4);
    chk("R4 all paid", rxEvent, 0);

    // R5: set and clear land in the same cycle
    cfg(2'd0, 6'd4);
    drive(1, 0, 0, 0, 4);
    chk("R5 setup owed", rxEvent, 1);
    drive(1, 1, 0, 0, 3);
    chk("R5 partial counts", rxEvent, 1);
    drive(1, 1, 0, 0, 1);
    chk("R5 simultaneous set and clear", rxEvent, 1);
    drive(0, 1, 0, 0, 4);
    chk("R5 paid after pair", rxEvent, 0);

    // R7 and R2 restart: clear with nothing owed
    cfg(2'd0, 6'd2);
    drive(1, 0, 0, 0, 1);
    cfg(2'd0, 6'd1);
    chk("R2 restart no event", rxEvent, 0);
    drive(0, 1, 0, 0, 1);
    chk("R7 clear with nothing owed", rxEvent, 0);
    drive(1, 0, 0, 0, 1);
    chk("R7 next set raises", rxEvent, 1);
    drive(0, 1, 0, 0, 1);
    chk("R7 paid", rxEvent, 0);

    // R2 clamp above 32
    cfg(2'd0, 6'd40);
    drive(1, 0, 0, 0, 31);
    chk("R2 clamp below 32", rxEvent, 0);
    drive(1, 0, 0, 0, 1);
    chk("R2 clamp at 32", rxEvent, 1);
    drive(0, 1, 0, 0, 32);
    chk("R2 clamp paid", rxEvent, 0);

    // R8 overflow, R1 full store
    cfg(2'd0, 6'd32);
    drive(1, 0, 0, 0, 64);
    chk("R6 two owed at full", rxEvent, 1);
    chk("R8 no overflow yet", rxOverflow, 0);
    drive(1, 0, 0, 0, 1);
    chk("R8 overflow set", rxOverflow, 1);
    drive(0, 1, 0, 0, 64);
    chk("R1 R8 drained", rxEvent, 0);
    chk("R10 overflow sticky", rxOverflow, 1);
    cfg(2'd2, 6'd1);
    chk("R10 overflow cleared", rxOverflow, 0);
    drive(1, 0, 0, 0, 31);
    chk("R8 dropped word not counted", rxEvent, 0);
    drive(1, 0, 0, 0, 1);
    chk("R8 count resumes", rxEvent, 1);
    drive(0, 1, 0, 0, 32);
    chk("R4 rx done", rxEvent, 0);

    // transmit direction
    cfg(2'd1, 6'd2);
    drive(0, 0, 1, 0, 4);
    chk("R3 tx dma side does not set", txEvent, 0);
    drive(0, 0, 0, 1, 2);
    chk("R3 tx pin side sets", txEvent, 1);
    drive(0, 0, 0, 1, 2);
    chk("R6 tx two owed", txEvent, 1);
    drive(0, 0, 1, 0, 2);
    chk("R6 tx one paid", txEvent, 1);
    drive(0, 0, 1, 0, 2);
    chk("R4 tx all paid", txEvent, 0);
    drive(0, 0, 0, 1, 4);
    chk("R6 tx drained owed", txEvent, 1);

    // R9 underflow and R10 clear priority
    chk("R9 no underflow yet", txUnderflow, 0);
    drive(0, 0, 0, 1, 1);
    chk("R9 underflow set", txUnderflow, 1);
    cfgWe = 1'b1; cfgAddr = 2'd2; cfgWdata = 6'd2; txPinPop = 1'b1;
    step();
    cfgWe = 1'b0; txPinPop = 1'b0;
    chk("R10 error beats clear", txUnderflow, 1);
    cfg(2'd2, 6'd2);
    chk("R10 underflow cleared", txUnderflow, 0);
    chk("R10 rx flag untouched", rxOverflow, 0);

    summary();
    $finish;
  end
endmodule